// File: doc/BRIEF.md
# Arm Sensor Readback and Interrupt Request Controller

This block sits between a host register interface and the analog and binary front end of a manipulator arm. It builds the 16-bit word returned on a host read from a two-bit read-select code. It can return the latched converter result or the live sensor status (two touch sensors and the stop button). It also keeps two interrupt request flags. The conversion flag tracks the converter handshake. The sensor flag records new touch or stop activity.

The host writes a channel number to start a conversion. That write clears the conversion flag, latches the channel, and moves a small state machine through three states: `CV_IDLE`, `CV_START` and `CV_WAIT`. The transitions are:
- Any state goes to `CV_START` on a channel write.
- `CV_START` goes to `CV_WAIT` after one cycle if no new write arrives.
- `CV_WAIT` goes to `CV_IDLE` when the converter reports completion. The result is latched and the conversion flag is raised at the same time.

Reading the converter word clears the conversion flag. Reading the sensor word clears the sensor flag. Each flag reaches its interrupt output only while the matching host interrupt enable is high.

Top module: `sense_irq_top`

## Requirements
- R1: With `rd_mode` = 2'b10, `rd_data` is the last latched 12-bit conversion result in bits 11:0, and bits 15:12 are zero.
- R2: With `rd_mode` = 2'b11, `rd_data` carries `panic_in` in bit 7 and `touch_in[1:0]` in bits 1:0. The sensor inputs are sampled through one register, so they appear one cycle after they change. All other bits are zero.
- R3: With `rd_mode` = 2'b00 or 2'b01, `rd_data` is zero, and a read strobe leaves both request flags unchanged.
- R4: A `chan_wr` pulse has three effects at the next edge: the conversion flag clears, `conv_chan` takes `chan_wdata`, and `conv_start` goes high (state `CV_START`). `conv_start` stays high for exactly one cycle after the last write.
- R5: In `CV_WAIT`, a `conv_done` pulse latches `conv_result` and sets the conversion flag at the next edge. A `conv_done` pulse in `CV_IDLE` or `CV_START` is ignored.
- R6: A read strobe with `rd_mode` = 2'b10 clears the conversion flag at the next edge. If a completion arrives in the same cycle, the flag is set instead.
- R7: While `touch_ie` is high, a rising level on any touch input or on `panic_in` sets the sensor flag two edges after the input changes. Held levels do not set it again, and with `touch_ie` low nothing sets it.
- R8: A read strobe with `rd_mode` = 2'b11 clears the sensor flag. If a new enabled rise is detected in the same cycle, the flag stays set.
- R9: `irq_a` is the conversion flag ANDed with `host_ie_a`. `irq_b` is the sensor flag ANDed with `host_ie_b`.
- R10: After reset both flags are zero, `conv_start` is low, `conv_chan` is zero and the latched result is zero.
- R11: A channel write in `CV_WAIT` restarts the handshake. The new channel is latched and `conv_start` pulses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_mode | input | 2 | Read-select code |
| rd_strobe | input | 1 | Host read of the input word this cycle |
| rd_data | output | 16 | Input word |
| chan_wr | input | 1 | Host write of the channel number |
| chan_wdata | input | 5 | Channel number written |
| conv_start | output | 1 | Conversion start pulse to the converter |
| conv_chan | output | 5 | Selected channel |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 12 | Converter result, valid with conv_done |
| touch_in | input | 2 | Touch sensor levels |
| panic_in | input | 1 | Stop button level |
| touch_ie | input | 1 | Enables sensor flag setting |
| host_ie_a | input | 1 | Host enable for irq_a |
| host_ie_b | input | 1 | Host enable for irq_b |
| irq_a | output | 1 | Conversion interrupt request |
| irq_b | output | 1 | Sensor interrupt request |

## Verification
The bench sweeps all 32 channels with distinct results and all 8 sensor combinations. This catches a swapped or shifted field, which would show up as a wrong bit in the read word. Several collisions are forced on purpose:
- A completion in the same cycle as a clearing read. A design that lets the clear win would drop a finished conversion.
- A new touch edge in the same cycle as a sensor read. A design that lets the clear win would lose that event.
- A write during `CV_WAIT`. A design that ignored it would never restart the converter.
- Reads in the two unused modes and completions outside `CV_WAIT`. These must not disturb either flag.

// File: rtl/sense_pkg.sv
package sense_pkg;
    typedef enum logic [1:0] {
        CV_IDLE  = 2'd0,
        CV_START = 2'd1,
        CV_WAIT  = 2'd2
    } conv_state_t;

    localparam logic [1:0] MODE_ADC   = 2'b10;
    localparam logic [1:0] MODE_SENSE = 2'b11;
endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
    import sense_pkg::*;
#(
    parameter int ADC_W  = 12,
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_wr,
    input  logic [CHAN_W-1:0] chan_wdata,
    input  logic              rd_clr,
    input  logic              conv_done,
    input  logic [ADC_W-1:0]  conv_result,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [ADC_W-1:0]  adc_word,
    output logic              req_a
);
    conv_state_t st, st_nxt;
    logic done_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CV_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            CV_IDLE:  if (chan_wr) st_nxt = CV_START;
            CV_START: st_nxt = chan_wr ? CV_START : CV_WAIT;
            CV_WAIT: begin
                if (chan_wr)        st_nxt = CV_START;
                else if (conv_done) st_nxt = CV_IDLE;
            end
            default:  st_nxt = CV_IDLE;
        endcase
    end

    assign done_hit   = (st == CV_WAIT) && conv_done && !chan_wr;
    assign conv_start = (st == CV_START);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_chan <= '0;
            adc_word  <= '0;
            req_a     <= 1'b0;
        end else begin
            if (chan_wr)  conv_chan <= chan_wdata;
            if (done_hit) adc_word  <= conv_result;
            if (chan_wr)       req_a <= 1'b0;
            else if (done_hit) req_a <= 1'b1;
            else if (rd_clr)   req_a <= 1'b0;
        end
    end

    // R4: write clears the flag and raises the start pulse
    a_r4_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
        chan_wr |=> (conv_start && !req_a));
    // R5: completion while waiting sets the flag
    a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CV_WAIT && conv_done && !chan_wr) |=> req_a);
    // R5: completion outside the wait state has no effect on the flag
    a_r5_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CV_WAIT && !chan_wr && !rd_clr) |=> $stable(req_a));
    // R6: a clearing read with no completion drops the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !(st == CV_WAIT && conv_done)) |=> !req_a);
    // R4: the start pulse ends one cycle after the last write
    a_r4_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !chan_wr) |=> !conv_start);
endmodule

// File: rtl/touch_req.sv
module touch_req #(
    parameter int N_TOUCH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TOUCH-1:0] touch_in,
    input  logic               panic_in,
    input  logic               touch_ie,
    input  logic               rd_clr,
    output logic [N_TOUCH:0]   sens_q,
    output logic               req_b
);
    localparam int NS = N_TOUCH + 1;

    logic [NS-1:0] sens_qq;
    logic [NS-1:0] rise;
    logic          set_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sens_q  <= '0;
            sens_qq <= '0;
        end else begin
            sens_q  <= {panic_in, touch_in};
            sens_qq <= sens_q;
        end
    end

    for (genvar i = 0; i < NS; i++) begin : g_edge
        assign rise[i] = sens_q[i] & ~sens_qq[i];
    end

    assign set_b = touch_ie & (|rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      req_b <= 1'b0;
        else if (set_b)  req_b <= 1'b1;
        else if (rd_clr) req_b <= 1'b0;
    end

    // R7: an enabled rise sets the flag
    a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_ie && (|rise)) |=> req_b);
    // R8: a clearing read with no new rise drops the flag
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !(touch_ie && (|rise))) |=> !req_b);
    // R7: with the enable low the flag never rises
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!touch_ie && !req_b) |=> !req_b);
endmodule

// File: rtl/read_mux.sv
module read_mux
    import sense_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADC_W     = 12,
    parameter int N_TOUCH   = 2,
    parameter int PANIC_BIT = 7
) (
    input  logic [1:0]        rd_mode,
    input  logic [ADC_W-1:0]  adc_word,
    input  logic [N_TOUCH:0]  sens_q,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] sense_word;

    always_comb begin
        sense_word = '0;
        sense_word[N_TOUCH-1:0] = sens_q[N_TOUCH-1:0];
        sense_word[PANIC_BIT]   = sens_q[N_TOUCH];
    end

    always_comb begin
        unique case (rd_mode)
            MODE_ADC:   rd_data = {{(WORD_W-ADC_W){1'b0}}, adc_word};
            MODE_SENSE: rd_data = sense_word;
            default:    rd_data = '0;
        endcase
    end

    // R1: the upper bits of the word are zero in converter mode
    always_comb begin
        if (rd_mode == MODE_ADC)
            a_r1_upper_zero: assert (rd_data[WORD_W-1:ADC_W] == '0);
    end
endmodule

// File: rtl/sense_irq_top.sv
module sense_irq_top
    import sense_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADC_W     = 12,
    parameter int CHAN_W    = 5,
    parameter int N_TOUCH   = 2,
    parameter int PANIC_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rd_mode,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    input  logic              chan_wr,
    input  logic [CHAN_W-1:0] chan_wdata,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_done,
    input  logic [ADC_W-1:0]  conv_result,
    input  logic [N_TOUCH-1:0] touch_in,
    input  logic              panic_in,
    input  logic              touch_ie,
    input  logic              host_ie_a,
    input  logic              host_ie_b,
    output logic              irq_a,
    output logic              irq_b
);
    logic             clr_a, clr_b, req_a, req_b;
    logic [ADC_W-1:0] adc_word;
    logic [N_TOUCH:0] sens_q;

    assign clr_a = rd_strobe && (rd_mode == MODE_ADC);
    assign clr_b = rd_strobe && (rd_mode == MODE_SENSE);

    conv_ctrl #(.ADC_W(ADC_W), .CHAN_W(CHAN_W)) u_conv (
        .clk(clk), .rst_n(rst_n), .chan_wr(chan_wr), .chan_wdata(chan_wdata),
        .rd_clr(clr_a), .conv_done(conv_done), .conv_result(conv_result),
        .conv_start(conv_start), .conv_chan(conv_chan), .adc_word(adc_word),
        .req_a(req_a)
    );

    touch_req #(.N_TOUCH(N_TOUCH)) u_touch (
        .clk(clk), .rst_n(rst_n), .touch_in(touch_in), .panic_in(panic_in),
        .touch_ie(touch_ie), .rd_clr(clr_b), .sens_q(sens_q), .req_b(req_b)
    );

    read_mux #(.WORD_W(WORD_W), .ADC_W(ADC_W), .N_TOUCH(N_TOUCH),
               .PANIC_BIT(PANIC_BIT)) u_mux (
        .rd_mode(rd_mode), .adc_word(adc_word), .sens_q(sens_q), .rd_data(rd_data)
    );

    assign irq_a = req_a & host_ie_a;
    assign irq_b = req_b & host_ie_b;

    // R3: reads in unused modes leave both flags alone
    a_r3_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rd_mode[1] && !chan_wr && !touch_ie && !conv_done)
        |=> ($stable(req_a) && $stable(req_b)));
endmodule

// File: tb/sense_irq_top_tb.sv
module sense_irq_top_tb;
    logic        clk = 0, rst_n = 0;
    logic [1:0]  rd_mode = 0;
    logic        rd_strobe = 0, chan_wr = 0, conv_done = 0;
    logic [4:0]  chan_wdata = 0;
    logic [11:0] conv_result = 0;
    logic [1:0]  touch_in = 0;
    logic        panic_in = 0, touch_ie = 0, host_ie_a = 1, host_ie_b = 1;
    logic [15:0] rd_data;
    logic        conv_start, irq_a, irq_b;
    logic [4:0]  conv_chan;
    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    sense_irq_top u_dut (
        .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .chan_wr(chan_wr), .chan_wdata(chan_wdata),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_result(conv_result), .touch_in(touch_in), .panic_in(panic_in),
        .touch_ie(touch_ie), .host_ie_a(host_ie_a), .host_ie_b(host_ie_b),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!done_flag) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        // R10 reset state
        chk(irq_a, 0, "R10 irq_a");
        chk(irq_b, 0, "R10 irq_b");
        chk(conv_start, 0, "R10 start");
        chk(conv_chan, 0, "R10 chan");
        rd_mode = 2'b10;
        #1 chk(rd_data, 0, "R10 result");

        // R4 R5 R1 R6 sweep over all channels
        for (int ch = 0; ch < 32; ch++) begin
            logic [11:0] v;
            v = 12'((ch * 127 + 5) & 12'hFFF);
            chan_wr = 1; chan_wdata = 5'(ch);
            step();
            chan_wr = 0;
            chk(conv_start, 1, "R4 start");
            chk(conv_chan, ch, "R4 chan");
            chk(irq_a, 0, "R4 cleared");
            step();
            chk(conv_start, 0, "R4 pulse end");
            conv_done = 1; conv_result = v;
            step();
            conv_done = 0; conv_result = 0;
            chk(irq_a, 1, "R5 set");
            chk(rd_data, {4'b0, v}, "R1 word");
            host_ie_a = 0; #1 chk(irq_a, 0, "R9 gate a"); host_ie_a = 1;
            rd_strobe = 1;
            step();
            rd_strobe = 0;
            chk(irq_a, 0, "R6 clear");
        end

        // R5 done in IDLE is ignored
        conv_done = 1; conv_result = 12'hABC;
        step();
        conv_done = 0;
        chk(irq_a, 0, "R5 idle done");
        chk(rd_data, {4'b0, 12'((31 * 127 + 5) & 12'hFFF)}, "R5 result kept");

        // R5 done in START ignored, R11 restart from WAIT
        chan_wr = 1; chan_wdata = 5'd3;
        step();
        chan_wr = 0; conv_done = 1; conv_result = 12'h111;
        step();
        conv_done = 0;
        chk(irq_a, 0, "R5 start done");
        chan_wr = 1; chan_wdata = 5'd9;
        step();
        chan_wr = 0;
        chk(conv_start, 1, "R11 restart");
        chk(conv_chan, 9, "R11 chan");
        step();
        // R6 completion and clearing read in one cycle: set wins
        conv_done = 1; conv_result = 12'h5A5; rd_strobe = 1;
        step();
        conv_done = 0; rd_strobe = 0;
        chk(irq_a, 1, "R6 set wins");
        chk(rd_data, 16'h05A5, "R1 word 2");

        // R3 unused modes read zero and do not clear
        touch_ie = 1; touch_in = 2'b01;
        step(); step();
        touch_ie = 0;
        chk(irq_b, 1, "R7 set");
        for (int m = 0; m < 2; m++) begin
            rd_mode = 2'(m); rd_strobe = 1;
            #1 chk(rd_data, 0, "R3 zero");
            step();
            rd_strobe = 0;
            chk(irq_a, 1, "R3 keep a");
            chk(irq_b, 1, "R3 keep b");
        end
        host_ie_b = 0; #1 chk(irq_b, 0, "R9 gate b"); host_ie_b = 1;

        // R2 sensor word sweep
        rd_mode = 2'b11;
        for (int s = 0; s < 8; s++) begin
            touch_in = 2'(s & 3); panic_in = s[2];
            step();
            chk(rd_data, {8'b0, s[2], 5'b0, 2'(s & 3)}, "R2 word");
        end
        // R8 clear
        touch_in = 0; panic_in = 0;
        step(); step();
        rd_strobe = 1;
        step();
        rd_strobe = 0;
        chk(irq_b, 0, "R8 clear");

        // R7 held level does not set again; disabled rise does not set
        step(); step();
        chk(irq_b, 0, "R7 no spurious");
        touch_in = 2'b10;
        step(); step(); step();
        chk(irq_b, 0, "R7 disabled");

        // R7 each source sets the flag when enabled, latency two edges
        touch_in = 0;
        step(); step();
        touch_ie = 1;
        for (int b = 0; b < 3; b++) begin
            if (b < 2) touch_in = 2'(1 << b); else panic_in = 1;
            step();
            chk(irq_b, 0, "R7 latency 1");
            step();
            chk(irq_b, 1, "R7 source");
            touch_in = 0; panic_in = 0;
            step(); step();
            rd_strobe = 1;
            step();
            rd_strobe = 0;
            chk(irq_b, 0, "R8 clear src");
        end

        // R8 new rise during clearing read keeps flag
        touch_in = 2'b01;
        step(); step();
        touch_in = 2'b11;
        step();
        rd_strobe = 1;
        step();
        rd_strobe = 0;
        chk(irq_b, 1, "R8 rise during clear");

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule